// File: doc/BRIEF.md
# Resolver Excitation Waveform Generator

This block drives the excitation winding of a resolver with a periodic sine wave. A phase sequencer walks through a programmable number of points per period and spreads the period length exactly over those points. Each point is looked up in an internal full-wave sine table, scaled by a mantissa over a power of two, and shifted by a signed offset. The result is clamped to the output code range.

The scaled level leaves the block in one of two ways. It can go out as a parallel code for an external converter. It can also go out as a complementary pulse-width pair, with a dead band per leg, a polarity choice per leg and a leg exchange. A one-cycle marker pulse flags the start of a selected quarter of the wave, so that a sampling converter can be triggered in step with the excitation.

Generation starts on a software start strobe, or a set number of cycles after the rising edge of a hardware trigger. Dropping the enable stops everything. After such a stop, only a software start can begin generation again.

Top module: `exc_gen`

## Requirements
- R1: `pts_code` k selects 2^(k+2) points per period. Codes above 8 act as 8, which gives 1024 points.
- R2: The table value of full-wave phase p (0..1023) is built as follows. Let quadrant q = p/256 and u = p%256. Let t = u for even q and t = 256-u for odd q. The magnitude is (t*(512-t))>>2, and it is negated when q is 2 or 3. Point j of N points uses phase j*(1024/N).
- R3: The level equals the table value times `mant` (unsigned), arithmetically right-shifted by `exp_sh` (rounding toward minus infinity), plus the signed `offset`. It is clamped to the range 0..2^DAC_W-1.
- R4: In converter mode (`pwm_mode`=0) with period P >= N, the output shows point floor(t*N/P) mod N at t cycles after point 0 appears. Point 0 therefore returns every P cycles.
- R5: `sync_pulse` is high for one cycle, in the same cycle that the output first shows the point whose phase is `sync_sel`*256. The codes 0, 1, 2 and 3 select 0, 90, 180 and 270 degrees.
- R6: In pulse mode the pulse period is 2^PWM_W cycles. The duty d is the top PWM_W bits of the level, and the raw pulse is high for the first d counts. Each point is held for `hold_code`+1 pulse periods.
- R7: Once the duty is steady, the positive leg is active for d-`dz_p` cycles of each pulse period. The negative leg is active for 2^PWM_W-d-`dz_n` cycles. The two legs are never active together.
- R8: `swap`=1 exchanges the two legs before polarity is applied. `inv_p` and `inv_n` then make the pins `pwm_p` and `pwm_n` active-low.
- R9: A `sw_start` strobe while `exc_en`=1 starts generation from point 0. A strobe while `exc_en`=0 has no effect.
- R10: With `hw_trig_en`=1, a rising edge of `hw_trig` starts generation `trig_delay` cycles later than it would with a delay of 0.
- R11: After reset, and within 5 cycles of `exc_en`=0, `dac_code` is 0, `sync_pulse` is low and both legs are inactive. A stop that ends a run or a pending trigger disarms the hardware trigger until the next accepted `sw_start`.
- R12: In converter mode both pins stay at their inactive level. In pulse mode `dac_code` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_en | input | 1 | Excitation enable |
| sw_start | input | 1 | Software start strobe |
| hw_trig_en | input | 1 | Accept the hardware trigger |
| hw_trig | input | 1 | Hardware trigger, rising edge |
| trig_delay | input | DLY_W | Cycles from trigger to start |
| period_cyc | input | PER_W | Excitation period in cycles (converter mode) |
| pts_code | input | 4 | Points-per-period code |
| pwm_mode | input | 1 | 1 = pulse pair, 0 = parallel code |
| hold_code | input | 4 | Pulse periods per point, minus one |
| mant | input | MAN_W | Amplitude mantissa |
| exp_sh | input | EXP_W | Amplitude right shift |
| offset | input | OFF_W | Signed level offset |
| dz_p | input | DZ_W | Positive-leg dead band |
| dz_n | input | DZ_W | Negative-leg dead band |
| inv_p | input | 1 | Pin p active-low |
| inv_n | input | 1 | Pin n active-low |
| swap | input | 1 | Exchange the legs |
| sync_sel | input | 2 | Quarter-phase marker select |
| dac_code | output | DAC_W | Parallel output code |
| pwm_p | output | 1 | Positive pulse pin |
| pwm_n | output | 1 | Negative pulse pin |
| sync_pulse | output | 1 | Quarter-phase marker |

## Verification
The marker pulse and the arrival of its point at the output are meant to fall in the same cycle. The bench starts every converter-mode run and every quarter-select run by waiting for the marker. In that same sampled cycle it compares `dac_code` with the computed value of the selected point, and it then checks every later cycle against the floor(t*N/P) schedule. A second coincidence is a period of exactly N cycles, where a new point arrives every cycle. Here the marker must land on the step into point 0 with no slip, and a directed case pins P to N to provoke it.

// File: rtl/exc_pkg.sv
package exc_pkg;
  // Full-wave phase resolution of the table (1024 entries).
  localparam int PH_W  = 10;
  localparam int TAB_W = 16;
  localparam int MAX_K = PH_W - 2;

  // Parabolic quarter-wave mirrored into a full period.
  function automatic logic signed [TAB_W-1:0] sine_pt(input int unsigned ph);
    int unsigned q, u, t, mag;
    q   = (ph >> (PH_W - 2)) % 4;
    u   = ph % (1 << (PH_W - 2));
    t   = (q % 2 == 1) ? (256 - u) : u;
    mag = (t * (512 - t)) >> 2;
    if (q >= 2) return TAB_W'(-int'(mag));
    return TAB_W'(mag);
  endfunction
endpackage

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
#(
  parameter int PER_W = 24,
  parameter int DLY_W = 16,
  parameter int PWM_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             sw_start,
  input  logic             hw_en,
  input  logic             hw_trig,
  input  logic [DLY_W-1:0] trig_delay,
  input  logic [PER_W-1:0] period,
  input  logic [3:0]       pts_code,
  input  logic             pwm_mode,
  input  logic [3:0]       hold_code,
  output logic             run,
  output logic [PH_W-1:0]  idx,
  output logic             new_pt,
  output logic [3:0]       k,
  output logic [PWM_W-1:0] pcnt
);
  localparam int SUM_W = PER_W + 1;

  logic             armed, pend, trig_q;
  logic [DLY_W-1:0] dly;
  logic [PER_W-1:0] acc;
  logic [3:0]       hcnt;
  logic [SUM_W-1:0] npts, sum;
  logic [PH_W-1:0]  idx_nxt;
  logic             step, start, pwm_wrap;

  always_comb begin
    k        = (pts_code > 4'(MAX_K)) ? 4'(MAX_K) : pts_code;
    npts     = SUM_W'(1) << (k + 4'd2);
    sum      = {1'b0, acc} + npts;
    pwm_wrap = (pcnt == '1);
    start    = en && !run && (sw_start || (pend && dly == '0));
    idx_nxt  = (idx + 1'b1) & PH_W'(npts - 1'b1);
    if (pwm_mode) step = pwm_wrap && (hcnt == hold_code);
    else          step = (sum >= {1'b0, period});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      armed  <= 1'b1;
      pend   <= 1'b0;
      trig_q <= 1'b0;
      dly    <= '0;
      acc    <= '0;
      idx    <= '0;
      new_pt <= 1'b0;
      hcnt   <= '0;
      pcnt   <= '0;
    end else begin
      trig_q <= hw_trig;
      new_pt <= 1'b0;
      if (!en) begin
        if (run || pend) armed <= 1'b0;
        run  <= 1'b0;
        pend <= 1'b0;
      end else if (start) begin
        run    <= 1'b1;
        pend   <= 1'b0;
        idx    <= '0;
        acc    <= '0;
        hcnt   <= '0;
        pcnt   <= '0;
        new_pt <= 1'b1;
        if (sw_start) armed <= 1'b1;
      end else if (!run) begin
        if (pend) dly <= dly - 1'b1;
        else if (hw_en && armed && hw_trig && !trig_q) begin
          pend <= 1'b1;
          dly  <= trig_delay;
        end
      end else begin
        pcnt <= pcnt + 1'b1;
        if (pwm_mode) begin
          if (pwm_wrap) hcnt <= step ? '0 : hcnt + 1'b1;
        end else begin
          acc <= step ? PER_W'(sum - {1'b0, period}) : PER_W'(sum);
        end
        if (step) begin
          idx    <= idx_nxt;
          new_pt <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/exc_shape.sv
module exc_shape
  import exc_pkg::*;
#(
  parameter int DAC_W = 12,
  parameter int MAN_W = 16,
  parameter int EXP_W = 5,
  parameter int OFF_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic                    new_pt,
  input  logic                    pwm_mode,
  input  logic [PH_W-1:0]         idx,
  input  logic [3:0]              k,
  input  logic [MAN_W-1:0]        mant,
  input  logic [EXP_W-1:0]        exp_sh,
  input  logic signed [OFF_W-1:0] offset,
  input  logic [1:0]              sync_sel,
  output logic [DAC_W-1:0]        lvl,
  output logic [DAC_W-1:0]        dac_code,
  output logic                    sync_pulse
);
  localparam int PROD_W = TAB_W + MAN_W + 1;
  localparam int SUM_W  = ((PROD_W > OFF_W) ? PROD_W : OFF_W) + 1;
  localparam int DEPTH  = 1 << PH_W;
  localparam logic signed [SUM_W-1:0] MAXC = SUM_W'((1 << DAC_W) - 1);

  logic signed [TAB_W-1:0] rom [0:DEPTH-1];
  initial begin
    for (int i = 0; i < DEPTH; i++) rom[i] = sine_pt(i);
  end

  logic [3:0]               sh_amt;
  logic [PH_W-1:0]          phase;
  logic signed [TAB_W-1:0]  tab_b;
  logic                     v_b, s_b, v_c, s_c;
  logic signed [PROD_W-1:0] prod_c, sh_c;
  logic signed [SUM_W-1:0]  sum_d;
  logic [DAC_W-1:0]         sat;

  always_comb begin
    sh_amt = 4'(PH_W - 2) - k;
    phase  = idx << sh_amt;
  end

  // ROM read kept free of reset so a block RAM can hold the table.
  always_ff @(posedge clk) tab_b <= rom[phase];

  always_comb begin
    sh_c  = prod_c >>> exp_sh;
    sum_d = SUM_W'(sh_c) + SUM_W'(offset);
    if (sum_d < 0)         sat = '0;
    else if (sum_d > MAXC) sat = DAC_W'(MAXC);
    else                   sat = DAC_W'(sum_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_b <= 1'b0; s_b <= 1'b0; v_c <= 1'b0; s_c <= 1'b0;
      prod_c <= '0; lvl <= '0; dac_code <= '0; sync_pulse <= 1'b0;
    end else begin
      v_b <= run;
      s_b <= run && new_pt && (phase == {sync_sel, {(PH_W-2){1'b0}}});
      v_c <= v_b;
      s_c <= s_b;
      prod_c <= PROD_W'(tab_b) * PROD_W'($signed({1'b0, mant}));
      lvl        <= v_c ? sat : '0;
      dac_code   <= (v_c && !pwm_mode) ? sat : '0;
      sync_pulse <= s_c && v_c;
    end
  end
endmodule

// File: rtl/exc_pwm.sv
module exc_pwm #(
  parameter int DAC_W = 12,
  parameter int PWM_W = 6,
  parameter int DZ_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             pwm_mode,
  input  logic [PWM_W-1:0] pcnt,
  input  logic [DAC_W-1:0] lvl,
  input  logic [DZ_W-1:0]  dz_p,
  input  logic [DZ_W-1:0]  dz_n,
  input  logic             inv_p,
  input  logic             inv_n,
  input  logic             swap,
  output logic             pwm_p,
  output logic             pwm_n
);
  logic [PWM_W-1:0] duty;
  logic [DZ_W-1:0]  age;
  logic             r, raw_n, lp, ln, act;

  always_comb begin
    act   = run && pwm_mode;
    raw_n = act && (pcnt < duty);
    lp    = act && r && (age >= dz_p);
    ln    = act && !r && (age >= dz_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      duty  <= '0;
      r     <= 1'b0;
      age   <= '0;
      pwm_p <= inv_p;
      pwm_n <= inv_n;
    end else begin
      if (pcnt == '1) duty <= lvl[DAC_W-1 -: PWM_W];
      r   <= raw_n;
      age <= (raw_n != r) ? '0 : ((age == '1) ? age : age + 1'b1);
      pwm_p <= (swap ? ln : lp) ^ inv_p;
      pwm_n <= (swap ? lp : ln) ^ inv_n;
    end
  end
endmodule

// File: rtl/exc_gen.sv
module exc_gen #(
  parameter int PER_W = 24,
  parameter int DLY_W = 16,
  parameter int DAC_W = 12,
  parameter int PWM_W = 6,
  parameter int DZ_W  = 8,
  parameter int MAN_W = 16,
  parameter int EXP_W = 5,
  parameter int OFF_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    exc_en,
  input  logic                    sw_start,
  input  logic                    hw_trig_en,
  input  logic                    hw_trig,
  input  logic [DLY_W-1:0]        trig_delay,
  input  logic [PER_W-1:0]        period_cyc,
  input  logic [3:0]              pts_code,
  input  logic                    pwm_mode,
  input  logic [3:0]              hold_code,
  input  logic [MAN_W-1:0]        mant,
  input  logic [EXP_W-1:0]        exp_sh,
  input  logic signed [OFF_W-1:0] offset,
  input  logic [DZ_W-1:0]         dz_p,
  input  logic [DZ_W-1:0]         dz_n,
  input  logic                    inv_p,
  input  logic                    inv_n,
  input  logic                    swap,
  input  logic [1:0]              sync_sel,
  output logic [DAC_W-1:0]        dac_code,
  output logic                    pwm_p,
  output logic                    pwm_n,
  output logic                    sync_pulse
);
  logic                     run, new_pt;
  logic [exc_pkg::PH_W-1:0] idx;
  logic [3:0]               k;
  logic [PWM_W-1:0]         pcnt;
  logic [DAC_W-1:0]         lvl;

  exc_seq #(.PER_W(PER_W), .DLY_W(DLY_W), .PWM_W(PWM_W)) u_seq (
    .clk(clk), .rst(rst), .en(exc_en), .sw_start(sw_start),
    .hw_en(hw_trig_en), .hw_trig(hw_trig), .trig_delay(trig_delay),
    .period(period_cyc), .pts_code(pts_code), .pwm_mode(pwm_mode),
    .hold_code(hold_code), .run(run), .idx(idx), .new_pt(new_pt),
    .k(k), .pcnt(pcnt)
  );

  exc_shape #(.DAC_W(DAC_W), .MAN_W(MAN_W), .EXP_W(EXP_W), .OFF_W(OFF_W)) u_shape (
    .clk(clk), .rst(rst), .run(run), .new_pt(new_pt), .pwm_mode(pwm_mode),
    .idx(idx), .k(k), .mant(mant), .exp_sh(exp_sh), .offset(offset),
    .sync_sel(sync_sel), .lvl(lvl), .dac_code(dac_code), .sync_pulse(sync_pulse)
  );

  exc_pwm #(.DAC_W(DAC_W), .PWM_W(PWM_W), .DZ_W(DZ_W)) u_pwm (
    .clk(clk), .rst(rst), .run(run), .pwm_mode(pwm_mode), .pcnt(pcnt),
    .lvl(lvl), .dz_p(dz_p), .dz_n(dz_n), .inv_p(inv_p), .inv_n(inv_n),
    .swap(swap), .pwm_p(pwm_p), .pwm_n(pwm_n)
  );
endmodule

// File: rtl/exc_gen_chk.sv
module exc_gen_chk #(
  parameter int DAC_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             exc_en,
  input logic             pwm_mode,
  input logic             inv_p,
  input logic             inv_n,
  input logic             pwm_p,
  input logic             pwm_n,
  input logic [DAC_W-1:0] dac_code,
  input logic             sync_pulse
);
  logic [2:0] idle_cnt;
  always_ff @(posedge clk) begin
    if (rst || exc_en)       idle_cnt <= '0;
    else if (idle_cnt != '1) idle_cnt <= idle_cnt + 1'b1;
  end

  // R7
  legs_apart_chk: assert property (@(posedge clk) disable iff (rst)
    !((pwm_p ^ $past(inv_p)) && (pwm_n ^ $past(inv_n))));

  // R5
  sync_single_chk: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |=> !sync_pulse);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_cnt >= 3'd5) |-> (dac_code == '0 && !sync_pulse));

  // R12
  dac_mode_pins_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(pwm_mode) |-> (pwm_p == $past(inv_p) && pwm_n == $past(inv_n)));

  // R12
  pwm_mode_code_chk: assert property (@(posedge clk) disable iff (rst)
    $past(pwm_mode) |-> (dac_code == '0));
endmodule

bind exc_gen exc_gen_chk #(.DAC_W(DAC_W)) u_exc_gen_chk (
  .clk(clk), .rst(rst), .exc_en(exc_en), .pwm_mode(pwm_mode),
  .inv_p(inv_p), .inv_n(inv_n), .pwm_p(pwm_p), .pwm_n(pwm_n),
  .dac_code(dac_code), .sync_pulse(sync_pulse)
);

// File: tb/exc_gen_bench.sv
module exc_gen_bench;
  localparam int CLK_P = 10;
  localparam int DAC_W = 12;
  localparam int PWM_W = 6;

  logic clk = 0, rst = 1, exc_en = 0, sw_start = 0, hw_trig_en = 0, hw_trig = 0;
  logic [15:0] trig_delay = 0;
  logic [23:0] period_cyc = 24'd64;
  logic [3:0]  pts_code = 0, hold_code = 0;
  logic        pwm_mode = 0, inv_p = 0, inv_n = 0, swap = 0;
  logic [15:0] mant = 0;
  logic [4:0]  exp_sh = 0;
  logic signed [31:0] offset = 0;
  logic [7:0]  dz_p = 0, dz_n = 0;
  logic [1:0]  sync_sel = 0;
  logic [DAC_W-1:0] dac_code;
  logic pwm_p, pwm_n, sync_pulse;

  exc_gen u_exc_gen (
    .clk(clk), .rst(rst), .exc_en(exc_en), .sw_start(sw_start),
    .hw_trig_en(hw_trig_en), .hw_trig(hw_trig), .trig_delay(trig_delay),
    .period_cyc(period_cyc), .pts_code(pts_code), .pwm_mode(pwm_mode),
    .hold_code(hold_code), .mant(mant), .exp_sh(exp_sh), .offset(offset),
    .dz_p(dz_p), .dz_n(dz_n), .inv_p(inv_p), .inv_n(inv_n), .swap(swap),
    .sync_sel(sync_sel), .dac_code(dac_code), .pwm_p(pwm_p), .pwm_n(pwm_n),
    .sync_pulse(sync_pulse)
  );

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int tab_f(input int ph);
    int q, u, t, m;
    q = ph / 256; u = ph % 256;
    t = (q % 2 == 1) ? 256 - u : u;
    m = (t * (512 - t)) / 4;
    return (q >= 2) ? -m : m;
  endfunction

  function automatic int lvl_f(input int j, input int kk, input int mn, input int ex, input int off);
    longint v;
    v = longint'(tab_f(j << (8 - kk))) * longint'(mn);
    v = v >>> ex;
    v = v + longint'(off);
    if (v < 0) return 0;
    if (v > (1 << DAC_W) - 1) return (1 << DAC_W) - 1;
    return int'(v);
  endfunction

  task automatic wait_sync(input int lim, output int n);
    n = 0;
    while (!sync_pulse && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) sw_start = 1;
    @(negedge clk) sw_start = 0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic stop_and_check(input string req);
    @(negedge clk) exc_en = 0;
    repeat (8) @(negedge clk);
    chk(dac_code == 0, req, dac_code, 0);
    chk(sync_pulse == 0, req, sync_pulse, 0);
  endtask

  // Converter-mode run, marker on point 0, two full periods compared.
  task automatic dac_run(input int pc, input int per, input int mn, input int ex, input int off, input string tag);
    int kk, np, n, expv;
    kk = (pc > 8) ? 8 : pc;
    np = 1 << (kk + 2);
    @(negedge clk);
    pts_code = 4'(pc); period_cyc = 24'(per); mant = 16'(mn); exp_sh = 5'(ex);
    offset = off; pwm_mode = 0; sync_sel = 0; exc_en = 1;
    pulse_start();
    wait_sync(per + 20, n);
    chk(n < per + 20, {"R9 start ", tag}, n, per);
    for (int t = 0; t < 2 * per; t++) begin
      expv = lvl_f((t * np / per) % np, kk, mn, ex, off);
      chk(dac_code == DAC_W'(expv), {"R2 R3 R4 ", tag}, dac_code, expv);
      chk(sync_pulse == (t % per == 0), {"R5 ", tag}, sync_pulse, (t % per == 0));
      if (t == 1) chk(pwm_p == inv_p && pwm_n == inv_n, {"R12 pins ", tag}, pwm_p, inv_p);
      @(negedge clk);
    end
    stop_and_check({"R11 stop ", tag});
  endtask

  task automatic sel_run(input int s);
    int n;
    @(negedge clk);
    pts_code = 4'd2; period_cyc = 24'd160; mant = 16'd40000; exp_sh = 5'd12;
    offset = 2048; pwm_mode = 0; sync_sel = 2'(s); exc_en = 1;
    pulse_start();
    wait_sync(400, n);
    chk(dac_code == DAC_W'(lvl_f(s * 4, 2, 40000, 12, 2048)), "R5 quarter value",
        dac_code, lvl_f(s * 4, 2, 40000, 12, 2048));
    @(negedge clk);
    wait_sync(400, n);
    chk(n + 1 == 160, "R5 quarter interval", n + 1, 160);
    stop_and_check("R11 stop sel");
  endtask

  task automatic pwm_run(input bit ip, input bit in_, input bit sw, input int exp_p, input int exp_n);
    int n, cp, cn, cb;
    @(negedge clk);
    pwm_mode = 1; pts_code = 0; hold_code = 4'd2; mant = 0; exp_sh = 0; offset = 1300;
    dz_p = 8'd3; dz_n = 8'd5; inv_p = ip; inv_n = in_; swap = sw; sync_sel = 0; exc_en = 1;
    pulse_start();
    wait_sync(2000, n);
    @(negedge clk);
    wait_sync(2000, n);
    chk(n + 1 == 4 * 3 * 64, "R6 point hold", n + 1, 768);
    cp = 0; cn = 0; cb = 0;
    for (int t = 0; t < 64; t++) begin
      @(negedge clk);
      cp += int'(pwm_p);
      cn += int'(pwm_n);
      cb += int'((pwm_p ^ inv_p) && (pwm_n ^ inv_n));
      if (t == 0) chk(dac_code == 0, "R12 code in pulse mode", dac_code, 0);
    end
    chk(cp == exp_p, "R7 R8 pin p high count", cp, exp_p);
    chk(cn == exp_n, "R7 R8 pin n high count", cn, exp_n);
    chk(cb == 0, "R7 overlap", cb, 0);
    stop_and_check("R11 stop pwm");
    @(negedge clk) pwm_mode = 0; inv_p = 0; inv_n = 0; swap = 0;
  endtask

  task automatic hw_measure(input int dl, output int n);
    @(negedge clk);
    pts_code = 0; period_cyc = 24'd40; mant = 16'd1000; exp_sh = 5'd4; offset = 2000;
    pwm_mode = 0; sync_sel = 0; hw_trig_en = 1; trig_delay = 16'(dl); exc_en = 1;
    @(negedge clk) hw_trig = 1;
    wait_sync(500, n);
    hw_trig = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, l0, l1;
    void'($urandom(32'd4711));
    do_reset();
    @(negedge clk);
    chk(dac_code == 0, "R11 reset code", dac_code, 0);
    chk(sync_pulse == 0, "R11 reset marker", sync_pulse, 0);
    chk(pwm_p == inv_p && pwm_n == inv_n, "R11 reset legs", pwm_p, inv_p);

    // Start strobe with enable low is ignored.
    @(negedge clk) exc_en = 0; period_cyc = 24'd40; sync_sel = 0;
    pulse_start();
    wait_sync(200, n);
    chk(n == 200, "R9 start while disabled", n, 200);

    // Directed converter-mode corners.
    dac_run(1, 8, 30000, 10, 2048, "period equals points");
    dac_run(12, 2048, 50000, 11, 2048, "R1 code clamp");
    dac_run(2, 100, 65535, 0, 100000, "R3 clamp high");
    dac_run(2, 100, 65535, 0, -100000, "R3 clamp low");
    // Random converter-mode configurations.
    for (int it = 0; it < 6; it++) begin
      int pc, np, per;
      pc  = int'($urandom % 6);
      np  = 1 << (pc + 2);
      per = np + int'($urandom % 300);
      dac_run(pc, per, int'($urandom % 65536), 8 + int'($urandom % 8),
              1000 + int'($urandom % 2000), "random");
    end
    for (int s = 0; s < 4; s++) sel_run(s);

    // Pulse mode: duty 20, dead bands 3 and 5.
    pwm_run(0, 0, 0, 17, 39);
    pwm_run(1, 0, 1, 25, 17);

    // Hardware trigger timing and disarm after stop.
    do_reset();
    hw_measure(0, l0);
    chk(l0 < 500, "R10 trigger starts", l0, 0);
    @(negedge clk) exc_en = 0;
    repeat (10) @(negedge clk);
    exc_en = 1;
    @(negedge clk) hw_trig = 1;
    wait_sync(300, n);
    hw_trig = 0;
    chk(n == 300, "R11 trigger disarmed", n, 300);
    pulse_start();
    wait_sync(100, n);
    chk(n < 100, "R9 software restart", n, 0);
    @(negedge clk) exc_en = 0;
    do_reset();
    hw_measure(37, l1);
    chk(l1 == l0 + 37, "R10 trigger delay", l1, l0 + 37);
    @(negedge clk) exc_en = 0; hw_trig_en = 0;
    repeat (8) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule